// File: doc/BRIEF.md
# Interframe Gap Timer with Pseudo-Random Spread

This block measures the quiet time between consecutive frames of a transmit burst. A send strobe captures three settings into the block: an 8-bit base time, a 6-bit per-frame time and a 7-bit seed for a pseudo-random generator. After each frame, the frame-done pulse and the index of that frame start an interval. When the interval has elapsed, the block raises `gap_done` for exactly one clock. The transmitter uses that pulse to start the next frame.

The interval is built from three parts. The first is the base time. The second is the per-frame time multiplied by the frame index. The third is the current value of a 7-bit linear feedback shift register. All three are counted in units of a 1 ms tick strobe. When the register holds a nonzero value, the three parts are counted one after another. When it holds zero, the base and per-frame parts are counted at the same time, so the gap equals the larger of the two. A zero seed keeps the register at zero, which selects this parallel counting.

All pins are plain control and status signals. No data stream crosses the block boundary, so the block has no valid/ready handshake and `gap_done` is never held back.

Top module: `ivt_gap_timer`

## Requirements
- R1: Reset (`rst_n` low) forces `gap_done` low. It also clears the captured base time, the captured per-frame time, the generator state, all counters and the busy state. A frame-done pulse that arrives after reset and before any send therefore yields `gap_done` on the following clock.
- R2: The `seed`, `base_time` and `frame_time` inputs are captured only on a clock where `send` is high. Changing them while `send` is low leaves later gap lengths unchanged.
- R3: The generator implements x^7 + x^6 + 1. One step maps state s to {s[5:0], s[6] XOR s[5]}. It steps once for each accepted frame-done pulse, and the random part of that gap is the stepped value.
- R4: A zero seed keeps the generator at zero on every step. The random part is then zero.
- R5: When the stepped generator value is nonzero, the gap is base + frame_time*index + generator value ticks. The three parts are counted one after another.
- R6: When the stepped generator value is zero, the base and per-frame parts count down together. The gap is then max(base, frame_time*index) ticks.
- R7: The per-frame part is the captured 6-bit frame time multiplied by the 3-bit `last_idx` sampled with the accepted frame-done pulse.
- R8: Each tick is consumed on the clock edge where `tick_1ms` is high. `gap_done` rises one clock after the edge that consumes the last needed tick. A part of zero adds no tick. If all parts are zero, `gap_done` rises one clock after the frame-done edge.
- R9: A frame-done pulse that arrives while an interval is counting, including the clock on which `gap_done` fires, is ignored. It does not step the generator or reload any counter.
- R10: `gap_done` is high for exactly one clock per accepted frame-done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| tick_1ms | input | 1 | One-clock strobe once per nominal millisecond |
| base_time | input | 8 | Base delay in ticks, captured on send |
| frame_time | input | 6 | Per-frame delay unit in ticks, captured on send |
| seed | input | 7 | Generator seed, captured on send |
| send | input | 1 | Burst start strobe that captures the settings |
| frame_done | input | 1 | Pulse marking the end of a transmitted frame |
| last_idx | input | 3 | Index of the frame just sent |
| gap_done | output | 1 | One-clock pulse: the next frame may start |

## Verification
The bound checker assumes that the counters are loaded only by an accepted frame-done pulse. It also assumes that `send` is the only way the generator state can change other than by stepping, which is why its generator properties are conditioned on `send` being low. The stimulus never raises `send` and `frame_done` on the same clock. New settings are sent only while the block is idle. The tick strobe is randomised while an interval runs, so its cycle-level timing is covered. Extra frame-done pulses are sprinkled only inside running intervals, where the block is required to ignore them.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic {
    GAP_SERIAL   = 1'b0,
    GAP_PARALLEL = 1'b1
  } gap_mode_e;
endpackage

// File: rtl/ivt_lfsr.sv
module ivt_lfsr #(
  parameter int W      = 7,
  parameter int TAP_HI = 6,
  parameter int TAP_LO = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] state,
  output logic [W-1:0] next_state
);
  // Fibonacci form: shift left, feed back XOR of two taps
  assign next_state = {state[W-2:0], state[TAP_HI] ^ state[TAP_LO]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= '0;
    else if (load) state <= load_val;
    else if (step) state <= next_state;
  end
endmodule

// File: rtl/ivt_down_ctr.sv
module ivt_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         is_zero
);
  assign is_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (load)               count <= load_val;
    else if (dec && !is_zero)    count <= count - W'(1);
  end
endmodule

// File: rtl/ivt_gap_timer.sv
module ivt_gap_timer
  import ivt_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int FRAME_W = 6,
  parameter int LFSR_W  = 7,
  parameter int IDX_W   = 3,
  parameter int TAP_HI  = 6,
  parameter int TAP_LO  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_1ms,
  input  logic [BASE_W-1:0]  base_time,
  input  logic [FRAME_W-1:0] frame_time,
  input  logic [LFSR_W-1:0]  seed,
  input  logic               send,
  input  logic               frame_done,
  input  logic [IDX_W-1:0]   last_idx,
  output logic               gap_done
);
  localparam int PROD_W = FRAME_W + IDX_W;

  logic [BASE_W-1:0]  base_q;
  logic [FRAME_W-1:0] frame_q;
  logic               busy_q;
  logic               gap_done_q;
  gap_mode_e          mode_q;

  logic [LFSR_W-1:0]  lfsr_q, lfsr_nxt;
  logic [BASE_W-1:0]  cnt_b;
  logic [PROD_W-1:0]  cnt_f;
  logic [LFSR_W-1:0]  cnt_r;
  logic               zb, zf, zr;
  logic               dec_b, dec_f, dec_r;
  logic               accept, all_zero;
  logic [PROD_W-1:0]  frame_prod;

  assign accept     = frame_done && !busy_q;
  assign all_zero   = zb && zf && zr;
  assign frame_prod = PROD_W'(frame_q) * PROD_W'(last_idx);

  // settings captured only on the burst start strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      frame_q <= '0;
    end else if (send) begin
      base_q  <= base_time;
      frame_q <= frame_time;
    end
  end

  ivt_lfsr #(.W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_lfsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (send),
    .load_val   (seed),
    .step       (accept),
    .state      (lfsr_q),
    .next_state (lfsr_nxt)
  );

  // tick steering: serial walks base, frame, random in turn;
  // parallel drains base and frame together
  always_comb begin
    dec_b = 1'b0;
    dec_f = 1'b0;
    dec_r = 1'b0;
    if (busy_q && tick_1ms) begin
      if (mode_q == GAP_PARALLEL) begin
        dec_b = !zb;
        dec_f = !zf;
        dec_r = zb && zf && !zr;
      end else begin
        dec_b = !zb;
        dec_f = zb && !zf;
        dec_r = zb && zf && !zr;
      end
    end
  end

  ivt_down_ctr #(.W(BASE_W)) u_cnt_base (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(base_q),
    .dec(dec_b), .count(cnt_b), .is_zero(zb)
  );

  ivt_down_ctr #(.W(PROD_W)) u_cnt_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(frame_prod),
    .dec(dec_f), .count(cnt_f), .is_zero(zf)
  );

  ivt_down_ctr #(.W(LFSR_W)) u_cnt_rand (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(lfsr_nxt),
    .dec(dec_r), .count(cnt_r), .is_zero(zr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      gap_done_q <= 1'b0;
      mode_q     <= GAP_SERIAL;
    end else begin
      gap_done_q <= busy_q && all_zero;
      if (accept) begin
        busy_q <= 1'b1;
        mode_q <= (lfsr_nxt == '0) ? GAP_PARALLEL : GAP_SERIAL;
      end else if (busy_q && all_zero) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign gap_done = gap_done_q;
endmodule

// File: rtl/ivt_gap_timer_chk.sv
module ivt_gap_timer_chk #(
  parameter int BASE_W  = 8,
  parameter int FRAME_W = 6,
  parameter int LFSR_W  = 7,
  parameter int IDX_W   = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick_1ms,
  input logic                      send,
  input logic                      gap_done,
  input logic                      busy_q,
  input logic                      mode_par,
  input logic [LFSR_W-1:0]         lfsr_q,
  input logic [BASE_W-1:0]         cnt_b,
  input logic [FRAME_W+IDX_W-1:0]  cnt_f,
  input logic [LFSR_W-1:0]         cnt_r
);
  localparam int PROD_W = FRAME_W + IDX_W;
  localparam int SUM_W  = PROD_W + 2;

  logic [SUM_W-1:0] total;
  logic             cnt_clear;
  assign total     = SUM_W'(cnt_b) + SUM_W'(cnt_f) + SUM_W'(cnt_r);
  assign cnt_clear = (cnt_b == '0) && (cnt_f == '0) && (cnt_r == '0);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done |=> !gap_done);

  a_r8_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done |-> $past(busy_q && cnt_clear));

  a_r4_zero_state_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr_q == '0 && !send) |=> lfsr_q == '0);

  a_r3_nonzero_state_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr_q != '0 && !send) |=> lfsr_q != '0);

  a_r9_idle_tick_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_1ms) |=> ($stable(cnt_b) && $stable(cnt_f) && $stable(cnt_r)));

  a_r6_parallel_no_rand: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mode_par) |-> cnt_r == '0);

  a_r6_parallel_joint_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mode_par && tick_1ms && cnt_b != '0 && cnt_f != '0) |=>
      (cnt_b == $past(cnt_b) - BASE_W'(1) && cnt_f == $past(cnt_f) - PROD_W'(1)));

  a_r5_serial_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mode_par && tick_1ms && !cnt_clear) |=>
      total == $past(total) - SUM_W'(1));
endmodule

bind ivt_gap_timer ivt_gap_timer_chk #(
  .BASE_W(BASE_W), .FRAME_W(FRAME_W), .LFSR_W(LFSR_W), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_1ms (tick_1ms),
  .send     (send),
  .gap_done (gap_done),
  .busy_q   (busy_q),
  .mode_par (mode_q == ivt_pkg::GAP_PARALLEL),
  .lfsr_q   (lfsr_q),
  .cnt_b    (cnt_b),
  .cnt_f    (cnt_f),
  .cnt_r    (cnt_r)
);

// File: tb/ivt_gap_timer_tb.sv
module ivt_gap_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1ms = 1'b0;
  logic [7:0] base_time = '0;
  logic [5:0] frame_time = '0;
  logic [6:0] seed = '0;
  logic       send = 1'b0;
  logic       frame_done = 1'b0;
  logic [2:0] last_idx = '0;
  logic       gap_done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done_flag = 1'b0;

  // bench model state
  int base_m = 0, frame_m = 0;
  logic [6:0] gen_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivt_gap_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .base_time(base_time),
    .frame_time(frame_time), .seed(seed), .send(send),
    .frame_done(frame_done), .last_idx(last_idx), .gap_done(gap_done)
  );

  // x^7 + x^6 + 1 step, from the requirement text
  function automatic logic [6:0] gen_step(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

  function automatic int gap_len(input int b, input int f, input int idx,
                                 input logic [6:0] g);
    int fp = f * idx;
    if (g == 7'd0) return (b > fp) ? b : fp;
    return b + fp + int'(g);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_send(input int b, input int f, input logic [6:0] s);
    @(negedge clk);
    base_time = 8'(b); frame_time = 6'(f); seed = s; send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    base_m = b; frame_m = f; gen_m = s;
  endtask

  // one accepted frame-done and the whole interval after it
  task automatic run_gap(input int idx, input string req, input int pct, input bit noise);
    int rem;
    int guard;
    bit exp;
    gen_m = gen_step(gen_m);
    rem = gap_len(base_m, frame_m, idx, gen_m);
    @(negedge clk);
    frame_done = 1'b1; last_idx = 3'(idx); tick_1ms = 1'b0;
    @(negedge clk);
    frame_done = 1'b0;
    check(gap_done == 1'b0, req, int'(gap_done), 0);
    guard = 0;
    forever begin
      tick_1ms   = (($urandom % 100) < pct);
      frame_done = noise && (($urandom % 4) == 0);
      last_idx   = 3'($urandom);
      exp = (rem == 0);
      @(negedge clk);
      check(gap_done == exp, req, int'(gap_done), int'(exp));
      if (exp) break;
      if (tick_1ms) rem--;
      guard++;
      if (guard > 8000) begin
        check(1'b0, req, guard, rem);
        break;
      end
    end
    tick_1ms = 1'b0; frame_done = 1'b0;
    @(negedge clk);
    check(gap_done == 1'b0, "R10 single pulse", int'(gap_done), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    check(gap_done == 1'b0, "R1 reset output", int'(gap_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gap_done == 1'b0, "R1 after reset", int'(gap_done), 0);

    // R1/R8: nothing sent yet, all parts zero -> pulse next clock
    run_gap(6, "R1 cleared settings", 100, 1'b0);

    // R8: everything zero via send
    do_send(0, 0, 7'd0);
    run_gap(7, "R8 all zero parts", 50, 1'b0);

    // R6/R4: zero seed, parallel counting, base larger
    do_send(10, 3, 7'd0);
    run_gap(2, "R6 parallel base wins", 70, 1'b0);
    run_gap(5, "R6 parallel frame wins R4", 70, 1'b0);
    check(gen_m == 7'd0, "R4 model stays zero", int'(gen_m), 0);

    // R5/R3/R7: serial with nonzero seed
    do_send(5, 4, 7'h41);
    run_gap(3, "R5 serial sum R7", 80, 1'b0);
    run_gap(0, "R3 second step R8 zero frame part", 80, 1'b0);

    // R2: settings changed without send have no effect
    do_send(2, 1, 7'h05);
    @(negedge clk);
    seed = 7'h7F; base_time = 8'd200; frame_time = 6'd63;
    run_gap(4, "R2 seed held until send", 100, 1'b0);
    run_gap(1, "R2 settings held", 100, 1'b0);

    // R9: frame-done noise inside running intervals
    do_send(12, 5, 7'h33);
    run_gap(3, "R9 busy frame-done ignored", 60, 1'b1);
    run_gap(2, "R9 generator not stepped by noise", 60, 1'b1);

    // large serial corner
    do_send(255, 63, 7'h7F);
    run_gap(7, "R5 max settings", 100, 1'b0);

    // R1: reset while counting
    do_send(40, 10, 7'h11);
    @(negedge clk);
    frame_done = 1'b1; last_idx = 3'd4;
    @(negedge clk);
    frame_done = 1'b0; tick_1ms = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b0; tick_1ms = 1'b0;
    @(negedge clk);
    check(gap_done == 1'b0, "R1 reset mid gap", int'(gap_done), 0);
    rst_n = 1'b1;
    base_m = 0; frame_m = 0; gen_m = '0;
    run_gap(4, "R1 state cleared after reset", 100, 1'b0);

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      if ((i % 4) == 0) begin
        logic [6:0] s;
        s = (($urandom % 4) == 0) ? 7'd0 : 7'($urandom);
        do_send(int'($urandom % 40), int'($urandom % 8), s);
      end
      run_gap(int'($urandom % 8), "R5/R6 random gap", 50 + int'($urandom % 50),
              (($urandom % 2) == 0));
    end

    done_flag = 1'b1;
    finish_run();
  end
endmodule